// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target device that models a 256-byte serial EEPROM. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only as an open-drain pull-down. A bus controller first addresses the device, then sets an internal word pointer. After that it either streams data bytes in or reads stored bytes back. A read can begin with a repeated Start that follows the pointer byte, or it can continue from wherever the pointer was last left.

Incoming write bytes are held in a small staging buffer. When that buffer fills, further bytes displace the oldest entries. A Stop that closes a write with data starts a self-timed programming interval. At the end of that interval the staged bytes are committed to the memory array. Until then the device ignores the bus: it acknowledges nothing, so the controller can poll it to learn when the write has finished.

Top module: `i2c_eeprom_target`

## Requirements
- R1: While reset is asserted and after it is released, `sda_oe` is low, and the device ignores the bus until it sees a Start, which is a falling SDA while SCL is high.
- R2: The first byte after a Start is a 7-bit address, MSB first, followed by a direction bit (1 = read). The device acknowledges by holding `sda_oe` high through the ninth SCL high phase, and does so only when address bits [6:3] equal 4'b1010. Bits [2:0] are ignored. On any other address it leaves SDA released until the next Start.
- R3: After a write-direction address, the next byte loads the word pointer and is acknowledged. Each later byte is acknowledged and staged for the current pointer, and the pointer then advances by one, wrapping from 255 to 0.
- R4: A write keeps only its last 16 data bytes. Earlier bytes of the same write never reach memory, and the memory locations they targeted keep their old contents.
- R5: A Stop after a write that carried at least one data byte starts a programming interval of PROG_CYCLES clock cycles, after which the staged bytes are in memory. A Stop after only the address, or after only the pointer byte, starts no interval.
- R6: During a programming interval the device acknowledges no byte, including its own address.
- R7: After a read-direction address, the device sends the byte at the word pointer MSB first, changing SDA only while SCL is low. It increments the pointer after each byte, wrapping from 255 to 0.
- R8: When the controller does not acknowledge a read byte, the device stops sending and keeps SDA released until the next Start or Stop.
- R9: A Start that arrives without a preceding Stop restarts address decoding, so a pointer write followed by a repeated Start and a read address returns data from that pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | High pulls the data line low; low releases it |

## Verification
Both bus inputs pass through a two-flop synchronizer and an edge register. An acknowledge or a read data bit therefore appears on `sda_oe` three to four system clocks after an SCL falling edge at the pin. The bench holds SCL low for ten clocks after each falling edge and samples the wired data line five clocks into the following high phase, so every sample falls well after the output has settled and well before the next edge. Memory results depend on the programming interval. The bench probes during that interval expecting refusals, and reads back only after waiting PROG_CYCLES plus a margin.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         PROG_CYCLES = 1000,
  parameter int         BUF_DEPTH   = 16,
  parameter int         MEM_DEPTH   = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int BW = $clog2(BUF_DEPTH);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_d, sda_d, scl_q, sda_q;
  logic       start_c, stop_c, rise, fall;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] shr, txb;
  logic       rd_dir, m_ack, busy;
  logic [AW-1:0] ptr;
  logic [TW-1:0] tmr;
  logic [BW-1:0] widx;
  logic [7:0]    mem   [MEM_DEPTH];
  logic [7:0]    bdata [BUF_DEPTH];
  logic [AW-1:0] baddr [BUF_DEPTH];
  logic [BUF_DEPTH-1:0] bval;

  assign scl_q   = scl_s[1];
  assign sda_q   = sda_s[1];
  assign start_c = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_c  = scl_q & scl_d & ~sda_d & sda_q;
  assign rise    = scl_q & ~scl_d;
  assign fall    = ~scl_q & scl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      shr    <= '0;
      txb    <= '0;
      rd_dir <= 1'b0;
      m_ack  <= 1'b0;
      ptr    <= '0;
      busy   <= 1'b0;
      tmr    <= '0;
      widx   <= '0;
      bval   <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) begin
        bdata[i] <= '0;
        baddr[i] <= '0;
      end
    end else begin
      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          bval <= '0;
          for (int i = 0; i < BUF_DEPTH; i++)
            if (bval[i]) mem[baddr[i]] <= bdata[i];
        end else begin
          tmr <= tmr - 1'b1;
        end
      end

      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (st == S_WR && |bval && !busy) begin
          busy <= 1'b1;
          tmr  <= TW'(PROG_CYCLES - 1);
        end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) shr <= {shr[6:0], sda_q};
          else            m_ack <= ~sda_q;
          cnt <= cnt + 1'b1;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (shr[7:4] == DEV_TYPE && !busy) begin
                  sda_oe <= 1'b1;
                  rd_dir <= shr[0];
                  if (!shr[0]) begin
                    bval <= '0;
                    widx <= '0;
                  end
                end else begin
                  st <= S_IDLE;
                end
              S_PTR: begin
                sda_oe <= 1'b1;
                ptr    <= shr[AW-1:0];
              end
              S_WR: begin
                sda_oe      <= 1'b1;
                bdata[widx] <= shr;
                baddr[widx] <= ptr;
                bval[widx]  <= 1'b1;
                widx        <= widx + 1'b1;
                ptr         <= ptr + 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if ((st == S_ADDR && rd_dir) || (st == S_RD && m_ack)) begin
              st     <= S_RD;
              txb    <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              ptr    <= ptr + 1'b1;
            end else begin
              sda_oe <= 1'b0;
              case (st)
                S_ADDR:  st <= S_PTR;
                S_PTR:   st <= S_WR;
                S_RD:    st <= S_IDLE;
                default: st <= st;
              endcase
            end
          end else if (st == S_RD && cnt != 4'd0) begin
            sda_oe <= ~txb[6];
            txb    <= {txb[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int PROG_CYCLES = 1000,
  parameter int TW          = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          sda_oe,
  input logic          busy,
  input logic [TW-1:0] tmr,
  input logic [2:0]    state
);
  a_r1_released_after_reset: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  a_r7_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);

  a_r5_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> (busy && tmr == $past(tmr) - 1'b1));

  a_r5_cycle_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(state) == 3'd3);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.PROG_CYCLES(PROG_CYCLES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .busy(busy), .tmr(tmr), .state(st)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
  localparam int PROG = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   nchk = 0;
  int   nfail = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_target #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(8);
    scl = 1'b1;   wt(8);
    sda_m = 1'b0; wt(8);
    scl = 1'b0;   wt(2);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(8);
    scl = 1'b1;   wt(8);
    sda_m = 1'b1; wt(8);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(8);
      scl = 1'b1;   wt(10);
      scl = 1'b0;   wt(2);
    end
    sda_m = 1'b1; wt(8);
    scl = 1'b1;   wt(5);
    ack = ~sda_bus;
    wt(5);
    scl = 1'b0;   wt(2);
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wt(8);
      scl = 1'b1;   wt(5);
      v = {v[6:0], sda_bus};
      wt(5);
      scl = 1'b0;   wt(2);
    end
    sda_m = ~give_ack; wt(8);
    scl = 1'b1;        wt(10);
    scl = 1'b0;        wt(2);
  endtask

  function automatic logic [7:0] dw(input int i);
    return 8'(8'h30 + i * 17);
  endfunction

  function automatic logic [7:0] dg(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    wt(5);
    chk(sda_oe == 1'b0, "R1 in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R1 after reset", sda_oe, 0);

    // R2 sweep of every 7-bit address, write direction
    for (int a = 0; a < 128; a++) begin
      do_start();
      tx_byte({7'(a), 1'b0}, ack);
      chk(ack == (a[6:3] == 4'b1010), "R2 address match", ack, (a[6:3] == 4'b1010));
      do_stop();
    end

    // R2 foreign read address: no ack, line stays released
    do_start();
    tx_byte(8'h91, ack);
    chk(!ack, "R2 foreign read nack", ack, 0);
    rx_byte(1'b0, v);
    chk(v == 8'hFF, "R2 released after miss", v, 8'hFF);
    do_stop();

    // R3 write five bytes at 0x10
    do_start();
    tx_byte(8'hA6, ack); chk(ack, "R2 write addr", ack, 1);
    tx_byte(8'h10, ack); chk(ack, "R3 pointer ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      tx_byte(dw(i), ack); chk(ack, "R3 data ack", ack, 1);
    end
    do_stop();
    // R6 refused during programming
    do_start();
    tx_byte(8'hA0, ack); chk(!ack, "R6 write addr busy", ack, 0);
    do_stop();
    do_start();
    tx_byte(8'hA1, ack); chk(!ack, "R6 read addr busy", ack, 0);
    do_stop();
    wt(PROG + 100);

    // R9 random read: pointer then repeated start
    do_start();
    tx_byte(8'hA0, ack); chk(ack, "R5 ack after cycle", ack, 1);
    tx_byte(8'h10, ack); chk(ack, "R3 pointer ack", ack, 1);
    do_start();
    tx_byte(8'hA1, ack); chk(ack, "R9 read addr after restart", ack, 1);
    for (int i = 0; i < 4; i++) begin
      rx_byte(i < 3, v);
      chk(v == dw(i), "R7 R9 read data", v, dw(i));
    end
    wt(4);
    chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    wt(10);
    chk(sda_bus == 1'b1, "R8 line high after nack", sda_bus, 1);
    do_stop();

    // R7 current-address read continues at 0x14
    do_start();
    tx_byte(8'hA3, ack); chk(ack, "R2 low bits ignored", ack, 1);
    rx_byte(1'b0, v);
    chk(v == dw(4), "R7 pointer advanced", v, dw(4));
    do_stop();

    // R4 overflow: 20 bytes from 0xF8, wraps through 0xFF
    do_start();
    tx_byte(8'hA0, ack);
    tx_byte(8'hF8, ack);
    for (int i = 0; i < 20; i++) begin
      tx_byte(dg(i), ack); chk(ack, "R4 data ack", ack, 1);
    end
    do_stop();
    wt(PROG + 100);
    do_start();
    tx_byte(8'hA0, ack);
    tx_byte(8'hF8, ack);
    do_start();
    tx_byte(8'hA1, ack);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] e;
      e = (i < 4) ? 8'h00 : dg(i);
      rx_byte(i < 19, v);
      chk(v == e, "R4 R7 kept last sixteen with wrap", v, e);
    end
    do_stop();

    // R5 stop after pointer only starts no cycle
    do_start();
    tx_byte(8'hA0, ack);
    tx_byte(8'h40, ack);
    do_stop();
    do_start();
    tx_byte(8'hA0, ack); chk(ack, "R5 no cycle after pointer-only", ack, 1);
    tx_byte(8'h40, ack);
    do_start();
    tx_byte(8'hA1, ack);
    rx_byte(1'b0, v);
    chk(v == 8'h00, "R5 memory unchanged", v, 0);
    do_stop();

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule